// File: doc/BRIEF.md
# I2C Character Display Sequencer

This block is a transmit-only I2C bus master for a serial character display controller. Once reset is released it brings the controller up with three fixed transactions: a setup of the controller modes, a wipe of the icon memory and a screen clear. After that it stays quiet until a refresh is requested. Each refresh sends one display frame: a five-character label followed by two decimal digits taken from the block's inputs and mapped into the controller's character set.

SCL is driven push-pull. SDA is open-drain: `sda_oe_o` high pulls the line low, and low releases it to the pull-up. Acknowledge bits are clocked but never read, and the block does no arbitration. Every bus step lasts `HALF_CYC` clock cycles, which is 10 µs at the default setting for a 125 MHz clock.

Top module: `char_lcd_i2c_seq`

## Requirements
- R1: While reset is held, `scl_o` is 1, `sda_oe_o` is 0 and `busy_o` is 1. On the first clock edge after release, the first transaction begins with a start condition.
- R2: A transaction opens with a start. SDA is pulled low while SCL is high for one step, then SCL goes low for one step. It closes with a stop. SCL is low with SDA pulled, then SCL is high with SDA pulled, then SCL is high with SDA released. Each of these is one step. Apart from start and stop, SDA moves only while SCL is low, and SCL and SDA never change in the same cycle.
- R3: Each byte goes out most significant bit first. Every bit takes three steps: SCL low, SCL high, SCL low. SDA holds the bit for all three steps, with `sda_oe_o` set to the inverse of the bit. One step is `HALF_CYC` cycles.
- R4: A ninth SCL pulse follows every byte, with SDA released for all three of its steps. The acknowledge is not sampled.
- R5: The first transaction is 0x74, 0x00, 0x31, 0x02, 0x05, 0x08, 0x30, 0x0C, 0x06, 0x02.
- R6: The second transaction is 0x74, 0x80, 0x4C, 0x40, 0x00, 0x18, then ten bytes of 0x00, then 0x0F and 0x10.
- R7: The third transaction is 0x74, 0x00, 0x30, 0x01, 0x0C.
- R8: A display frame is 0x74, 0x80, 0x8C, 0x40, 0x20, 0xC9, 0xE4, 0xBA, 0x20, then 0xB0 plus `tens_i`, then 0xB0 plus `units_i`.
- R9: Exactly one idle cycle (SCL 1, SDA released) separates consecutive transactions. `busy_o` stays 1 from reset until the third transaction has ended. After that it is 1 exactly while a transaction is on the bus. The bus is idle whenever `busy_o` is 0.
- R10: Both digits are captured on the edge where a frame begins. Later changes to `tens_i` or `units_i` have no effect on that frame.
- R11: When `refresh_i` is high on an edge where no frame can begin, the request is held. This covers a transaction in progress and the idle cycles of the setup sequence. A held request is served at the next idle cycle after setup. Several such requests merge into one frame.
- R12: When `refresh_i` stays high, frames follow one another with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tens_i | input | 4 | Tens digit, BCD |
| units_i | input | 4 | Units digit, BCD |
| refresh_i | input | 1 | Request one display frame |
| scl_o | output | 1 | I2C clock level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Setup pending or transaction on the bus |

## Verification
The properties treat the bus as owned by this master. No slave stretches SCL and no other master drives SDA, so the line levels seen equal the levels driven. They also assume `refresh_i`, `tens_i` and `units_i` are synchronous to `clk`, and that the digits stay within 0 to 9. The stimulus changes every input one nanosecond after a rising edge and uses only decimal digit values. Refresh requests are placed during setup, inside frames and as a long held level, so that merging, deferral and back-to-back framing all occur.

// File: rtl/char_lcd_i2c_seq.sv
module char_lcd_i2c_seq #(
  parameter int HALF_CYC = 1250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] tens_i,
  input  logic [3:0] units_i,
  input  logic       refresh_i,
  output logic       scl_o,
  output logic       sda_oe_o,
  output logic       busy_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] STEP_LAST = CW'(HALF_CYC - 1);

  typedef enum logic [1:0] {P_IDLE, P_START, P_BITS, P_STOP} phase_t;

  phase_t        phase;
  logic [1:0]    txn, boot_left, sub;
  logic [4:0]    byte_idx;
  logic [3:0]    bit_idx;
  logic [CW-1:0] cnt;
  logic          pend;
  logic [3:0]    tens_q, units_q;

  function automatic logic [7:0] byte_at(input logic [1:0] t, input logic [4:0] i,
                                         input logic [3:0] tn, input logic [3:0] un);
    logic [7:0] b;
    b = 8'h00;
    if (i == 5'd0) b = 8'h74;
    else begin
      case (t)
        2'd0: case (i)
          5'd2: b = 8'h31;
          5'd3: b = 8'h02;
          5'd4: b = 8'h05;
          5'd5: b = 8'h08;
          5'd6: b = 8'h30;
          5'd7: b = 8'h0C;
          5'd8: b = 8'h06;
          5'd9: b = 8'h02;
          default: b = 8'h00;
        endcase
        2'd1: case (i)
          5'd1:  b = 8'h80;
          5'd2:  b = 8'h4C;
          5'd3:  b = 8'h40;
          5'd5:  b = 8'h18;
          5'd16: b = 8'h0F;
          5'd17: b = 8'h10;
          default: b = 8'h00;
        endcase
        2'd2: case (i)
          5'd2: b = 8'h30;
          5'd3: b = 8'h01;
          5'd4: b = 8'h0C;
          default: b = 8'h00;
        endcase
        default: case (i)
          5'd1:  b = 8'h80;
          5'd2:  b = 8'h8C;
          5'd3:  b = 8'h40;
          5'd4:  b = 8'h20;
          5'd5:  b = 8'hC9;
          5'd6:  b = 8'hE4;
          5'd7:  b = 8'hBA;
          5'd8:  b = 8'h20;
          5'd9:  b = 8'hB0 + {4'h0, tn};
          5'd10: b = 8'hB0 + {4'h0, un};
          default: b = 8'h00;
        endcase
      endcase
    end
    return b;
  endfunction

  function automatic logic [4:0] last_of(input logic [1:0] t);
    case (t)
      2'd0:    return 5'd9;
      2'd1:    return 5'd17;
      2'd2:    return 5'd4;
      default: return 5'd10;
    endcase
  endfunction

  logic [7:0] cur_byte;
  logic       step_end, last_byte;

  assign cur_byte  = byte_at(txn, byte_idx, tens_q, units_q);
  assign step_end  = (cnt == STEP_LAST);
  assign last_byte = (byte_idx == last_of(txn));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      txn       <= 2'd0;
      boot_left <= 2'd3;
      sub       <= 2'd0;
      byte_idx  <= 5'd0;
      bit_idx   <= 4'd0;
      cnt       <= '0;
      pend      <= 1'b0;
      tens_q    <= 4'd0;
      units_q   <= 4'd0;
    end else if (phase == P_IDLE) begin
      cnt      <= '0;
      sub      <= 2'd0;
      byte_idx <= 5'd0;
      bit_idx  <= 4'd0;
      if (boot_left != 2'd0) begin
        phase     <= P_START;
        txn       <= 2'd3 - boot_left;
        boot_left <= boot_left - 2'd1;
        pend      <= pend | refresh_i;
      end else if (pend | refresh_i) begin
        phase   <= P_START;
        txn     <= 2'd3;
        tens_q  <= tens_i;
        units_q <= units_i;
        pend    <= 1'b0;
      end
    end else begin
      pend <= pend | refresh_i;
      if (!step_end) cnt <= cnt + 1'b1;
      else begin
        cnt <= '0;
        case (phase)
          P_START:
            if (sub == 2'd0) sub <= 2'd1;
            else begin
              phase <= P_BITS;
              sub   <= 2'd0;
            end
          P_BITS:
            if (sub != 2'd2) sub <= sub + 2'd1;
            else begin
              sub <= 2'd0;
              if (bit_idx != 4'd8) bit_idx <= bit_idx + 4'd1;
              else begin
                bit_idx <= 4'd0;
                if (last_byte) phase <= P_STOP;
                else byte_idx <= byte_idx + 5'd1;
              end
            end
          P_STOP:
            if (sub != 2'd2) sub <= sub + 2'd1;
            else phase <= P_IDLE;
          default: phase <= P_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (phase)
      P_START: begin scl_o = (sub == 2'd0); sda_oe_o = 1'b1; end
      P_BITS: begin
        scl_o    = (sub == 2'd1);
        sda_oe_o = (bit_idx == 4'd8) ? 1'b0 : ~cur_byte[3'd7 - bit_idx[2:0]];
      end
      P_STOP:  begin scl_o = (sub != 2'd0); sda_oe_o = (sub != 2'd2); end
      default: begin scl_o = 1'b1; sda_oe_o = 1'b0; end
    endcase
  end

  assign busy_o = (phase != P_IDLE) | (boot_left != 2'd0);
endmodule

module char_lcd_i2c_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic scl,
  input logic oe,
  input logic busy
);
  logic       scl_q, oe_q, any_byte;
  logic [3:0] pos;
  logic       start_evt, stop_evt, rise;

  assign start_evt = scl && scl_q && oe && !oe_q;
  assign stop_evt  = scl && scl_q && !oe && oe_q;
  assign rise      = scl && !scl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1; oe_q <= 1'b0; pos <= 4'd0; any_byte <= 1'b0;
    end else begin
      scl_q <= scl;
      oe_q  <= oe;
      if (start_evt) begin
        pos <= 4'd0; any_byte <= 1'b0;
      end else if (rise) begin
        if (pos == 4'd8) begin pos <= 4'd0; any_byte <= 1'b1; end
        else pos <= pos + 4'd1;
      end
    end
  end

  assert_ack_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && pos == 4'd8) |-> !oe);
  assert_whole_bytes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |-> (pos == 4'd1 && any_byte));
  assert_one_line_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !((scl != scl_q) && (oe != oe_q)));
  assert_start_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> busy);
  assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl && !oe));
endmodule

bind char_lcd_i2c_seq char_lcd_i2c_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl_o), .oe(sda_oe_o), .busy(busy_o)
);

// File: tb/tb_char_lcd_i2c_seq.sv
module tb_char_lcd_i2c_seq;
  localparam int HALF = 2;

  logic       clk = 1'b0, rst_n = 1'b0, refresh = 1'b0;
  logic [3:0] tens = 4'd0, units = 4'd0;
  logic       scl, oe, busy;

  always #4 clk = ~clk;

  char_lcd_i2c_seq #(.HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .tens_i(tens), .units_i(units), .refresh_i(refresh),
    .scl_o(scl), .sda_oe_o(oe), .busy_o(busy)
  );

  typedef struct { bit s; bit o; bit b; string tag; } exp_t;
  exp_t q[$];

  byte unsigned init_b[$] = '{8'h74, 8'h00, 8'h31, 8'h02, 8'h05, 8'h08, 8'h30, 8'h0C, 8'h06, 8'h02};
  byte unsigned icon_b[$] = '{8'h74, 8'h80, 8'h4C, 8'h40, 8'h00, 8'h18, 8'h00, 8'h00, 8'h00,
                              8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h10};
  byte unsigned clr_b[$]  = '{8'h74, 8'h00, 8'h30, 8'h01, 8'h0C};

  int    vectors = 0, miscompares = 0, cycle = 0, starts = 0, setup_left = 3;
  bit    pend = 0, last_idle = 1, rst_seen = 0, r_seen = 0, done = 0, p_scl = 1, p_oe = 0;
  logic [3:0] t_seen = 0, u_seen = 0;
  string frame_tag = "R8";

  task automatic put(bit s, bit o, string tg);
    exp_t e;
    e.s = s; e.o = o; e.b = 1'b1; e.tag = tg;
    for (int k = 0; k < HALF; k++) q.push_back(e);
  endtask

  task automatic put_txn(byte unsigned bl[$], string tg);
    put(1, 1, "R2"); put(0, 1, "R2");
    foreach (bl[j]) begin
      for (int k = 7; k >= 0; k--) begin
        bit o;
        o = !bl[j][k];
        put(0, o, tg); put(1, o, "R3"); put(0, o, tg);
      end
      put(0, 0, "R4"); put(1, 0, "R4"); put(0, 0, "R4");
    end
    put(0, 1, "R2"); put(1, 1, "R2"); put(1, 0, "R2");
  endtask

  task automatic check(bit ok, string tag, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycle    <= cycle + 1;
    rst_seen <= rst_n;
    r_seen   <= refresh;
    t_seen   <= tens;
    u_seen   <= units;
  end

  always @(negedge clk) begin
    if (rst_seen && !done) begin
      exp_t e;
      byte unsigned fb[$];
      if (last_idle) begin
        if (setup_left > 0) begin
          if (setup_left == 3) put_txn(init_b, "R5");
          else if (setup_left == 2) put_txn(icon_b, "R6");
          else put_txn(clr_b, "R7");
          setup_left--;
          pend = pend | r_seen;
        end else if (pend || r_seen) begin
          fb = '{8'h74, 8'h80, 8'h8C, 8'h40, 8'h20, 8'hC9, 8'hE4, 8'hBA, 8'h20,
                 8'(8'hB0 + t_seen), 8'(8'hB0 + u_seen)};
          put_txn(fb, frame_tag);
          pend = 0;
        end
      end else pend = pend | r_seen;
      if (q.size() == 0) begin
        e.s = 1; e.o = 0; e.b = (setup_left > 0); e.tag = "R9";
        last_idle = 1;
      end else begin
        e = q.pop_front();
        last_idle = 0;
      end
      check({scl, oe, busy} === {e.s, e.o, e.b}, e.tag, {scl, oe, busy}, {e.s, e.o, e.b});
      if (scl && p_scl && oe && !p_oe) starts++;
      p_scl = scl;
      p_oe  = oe;
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wait_quiet();
    int z = 0;
    while (z < 4) begin
      @(negedge clk); #1;
      if (!busy) z++; else z = 0;
    end
    @(posedge clk); #1;
  endtask

  task automatic pulse();
    refresh = 1'b1; tick(1); refresh = 1'b0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    if (cycle > 150000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL R9: watchdog expired, got %0d cycles expected under 150000", cycle);
      report();
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (5) @(negedge clk);
    check(scl === 1'b1, "R1", scl, 1);
    check(oe === 1'b0, "R1", oe, 0);
    check(busy === 1'b1, "R1", busy, 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    tick(2);
    check(oe === 1'b1 && scl === 1'b1, "R1", {scl, oe}, 2'b11);
    // R11: requests during setup merge into one frame after setup
    tick(40); pulse();
    tick(700); refresh = 1'b1; tick(3); refresh = 1'b0;
    tick(300); pulse();
    wait_quiet();
    check(starts == 4, "R11", starts, 4);
    check(busy === 1'b0, "R9", busy, 0);
    // R8: several digit patterns
    tens = 4'd9; units = 4'd9; pulse(); wait_quiet();
    tens = 4'd0; units = 4'd0; pulse(); wait_quiet();
    tens = 4'd4; units = 4'd7; pulse(); tick(100); pulse(); wait_quiet();
    check(starts == 8, "R11", starts, 8);
    // R10: digits change mid-frame
    frame_tag = "R10";
    tens = 4'd2; units = 4'd5; pulse(); tick(200);
    tens = 4'd7; units = 4'd1; wait_quiet();
    frame_tag = "R8";
    // R12: held request gives back-to-back frames
    s0 = starts;
    frame_tag = "R12";
    tens = 4'd3; units = 4'd6; refresh = 1'b1;
    tick(1300); refresh = 1'b0;
    wait_quiet();
    check(starts - s0 >= 2, "R12", starts - s0, 2);
    done = 1;
    report();
    $finish;
  end
endmodule